// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the software-visible state of one DMA channel. It has four 32-bit words on a 32-bit register bus: a control and status word, a channel address, a byte count and an upper address base. Software uses the control word to enable the channel, to reset the attached peripheral, to request a FIFO drain and to mask the channel interrupt. The peripheral reports its interrupt as a level. The block turns the edges of that level into a pending flag and drives a registered interrupt line.

Only the control word has side effects on write. Its status and version bits are protected from software. A write of all zeros becomes a drain request. A write to the address word marks the channel as loaded. The byte count and upper base words are plain storage.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, words 1 to 3 read 0, and `irq_out`, `periph_rst_pulse` and `chan_en` are low.
- R2: An access is accepted only when `acc_size` is 2 (four bytes). The word index is `acc_addr[3:2]`, and higher address bits are ignored. A rejected write changes nothing, and a rejected read returns 0.
- R3: Words 2 and 3 store all 32 written bits with no side effect and read back unchanged.
- R4: A write to word 1 stores the value and sets control bit 26 (loaded).
- R5: Control bits 31..25 and 2..0 cannot be changed by a write. Bits 31..28 always read 0xA.
- R6: A control write of exactly 0 is stored as a write of 0x00000040 (drain bit 6 only).
- R7: A control write with bit 7 clear and bit 6 set stores bit 6 as 0. With bit 7 set, bit 6 is stored as written.
- R8: A control write with bit 7 set makes `periph_rst_pulse` high for exactly the one cycle after the write edge.
- R9: `chan_en` follows control bit 9. It rises when a write sets bit 9 and falls when a write clears it.
- R10: A rising edge on `periph_irq` sets control bit 0 (pending). A falling edge clears it.
- R11: `irq_out` is registered and equals pending (bit 0) AND enable (bit 4) after every update, including a control write that only changes bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code; only 2 (32-bit) is accepted |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| periph_irq | input | 1 | Peripheral interrupt level |
| irq_out | output | 1 | Channel interrupt to the system |
| periph_rst_pulse | output | 1 | One-cycle reset to the peripheral |
| chan_en | output | 1 | Channel enabled level |

## Verification
Control writes are tried with five patterns: all ones, zero, drain alone, drain together with reset, and plain enable or mask values. Comparing the stored words separates the zero substitution, the drain clearing and the read-only merge. The interrupt is tried with the edge arriving while the mask is off and then unmasking, with masking again while pending, and with a falling edge while unmasked. These cases show whether the output is recomputed on writes or only on events. Aliased offsets and wrong-size accesses show that only bits 3:2 select the word and that rejected accesses leave all state untouched.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
  localparam logic [1:0]  SIZE_WORD = 2'd2;

  localparam logic [3:0]        VERSION   = 4'hA;
  localparam logic [WORD_W-1:0] RO_MASK   = 32'hFE00_0007;
  localparam logic [WORD_W-1:0] CTRL_RST  = {VERSION, 28'h0};

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_TOMEM  = 8;
  localparam int unsigned B_EN     = 9;
  localparam int unsigned B_LOADED = 26;

  // Rewrite the software value before it is merged into the control word
  function automatic logic [WORD_W-1:0] ctrl_filter(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = v;
    if (!v[B_PRST]) begin
      if (v[B_DRAIN])      r[B_DRAIN] = 1'b0;
      else if (v == '0)    r = WORD_W'(1) << B_DRAIN;
    end
    return r;
  endfunction

  // Keep the protected bits of the old word and force the version code
  function automatic logic [WORD_W-1:0] ctrl_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] v);
    return (old_w & RO_MASK) | (v & ~RO_MASK) | CTRL_RST;
  endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dma_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_WORDS-1:0] wr_stb,
  output logic              rd_ok,
  output logic [IDX_W-1:0]  idx
);
  logic size_ok;

  assign size_ok = (acc_size == SIZE_WORD);
  assign idx     = acc_addr[IDX_W+1:2];
  assign rd_ok   = acc_valid && !acc_write && size_ok;

  generate
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_stb
      assign wr_stb[i] = acc_valid && acc_write && size_ok && (idx == IDX_W'(i));
    end
  endgenerate
endmodule

// File: rtl/dcr_word.sv
module dcr_word
  import dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              set_loaded,
  input  logic              periph_irq,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              irq_q,
  output logic              rst_pulse_q,
  output logic              irq_rise,
  output logic              irq_fall
);
  logic              irq_in_q;
  logic [WORD_W-1:0] wr_val;
  logic [WORD_W-1:0] ctrl_next;

  assign irq_rise = periph_irq && !irq_in_q;
  assign irq_fall = !periph_irq && irq_in_q;
  assign wr_val   = ctrl_filter(wdata);

  always_comb begin
    ctrl_next = ctrl_q;
    if (wr)         ctrl_next = ctrl_merge(ctrl_q, wr_val);
    if (set_loaded) ctrl_next[B_LOADED] = 1'b1;
    if (irq_rise)   ctrl_next[B_PEND] = 1'b1;
    if (irq_fall)   ctrl_next[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_RST;
      irq_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
      irq_in_q    <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_next;
      irq_q       <= ctrl_next[B_PEND] && ctrl_next[B_IEN];
      rst_pulse_q <= wr && wdata[B_PRST];
      irq_in_q    <= periph_irq;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              periph_irq,
  output logic              irq_out,
  output logic              periph_rst_pulse,
  output logic              chan_en
);
  logic [NUM_WORDS-1:0] wr_stb;
  logic                 rd_ok;
  logic [IDX_W-1:0]     idx;
  logic [WORD_W-1:0]    words [NUM_WORDS];
  logic                 irq_rise;
  logic                 irq_fall;

  dcr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .wr_stb    (wr_stb),
    .rd_ok     (rd_ok),
    .idx       (idx)
  );

  dcr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr_stb[0]),
    .wdata       (acc_wdata),
    .set_loaded  (wr_stb[1]),
    .periph_irq  (periph_irq),
    .ctrl_q      (words[0]),
    .irq_q       (irq_out),
    .rst_pulse_q (periph_rst_pulse),
    .irq_rise    (irq_rise),
    .irq_fall    (irq_fall)
  );

  generate
    for (genvar i = 1; i < NUM_WORDS; i++) begin : g_word
      dcr_word u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_stb[i]),
        .wdata (acc_wdata),
        .q     (words[i])
      );
    end
  endgenerate

  assign chan_en   = words[0][B_EN];
  assign acc_rdata = rd_ok ? words[idx] : '0;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WORDS-1:0] wr_stb,
  input logic [31:0]          acc_wdata,
  input logic [31:0]          ctrl_w,
  input logic [31:0]          cnt_w,
  input logic                 irq_rise,
  input logic                 irq_fall,
  input logic                 irq_out,
  input logic                 periph_rst_pulse,
  input logic                 chan_en
);
  assert_version_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w[31:28] == VERSION);

  assert_irq_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (ctrl_w[B_PEND] && ctrl_w[B_IEN]));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse |=> !periph_rst_pulse);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse |-> $past(wr_stb[0] && acc_wdata[B_PRST]));

  assert_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[1] |=> ctrl_w[B_LOADED]);

  assert_pend_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> ctrl_w[B_PEND]);

  assert_pend_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall |=> !ctrl_w[B_PEND]);

  assert_enable_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[0] |=> (chan_en == $past(acc_wdata[B_EN])));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[2] |=> $stable(cnt_w));

  assert_stb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_stb           (wr_stb),
  .acc_wdata        (acc_wdata),
  .ctrl_w           (words[0]),
  .cnt_w            (words[2]),
  .irq_rise         (irq_rise),
  .irq_fall         (irq_fall),
  .irq_out          (irq_out),
  .periph_rst_pulse (periph_rst_pulse),
  .chan_en          (chan_en)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [7:0]  acc_addr = 8'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic [31:0] acc_rdata;
  logic        periph_irq = 1'b0;
  logic        irq_out;
  logic        periph_rst_pulse;
  logic        chan_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] ctl;   // expected control word, tracked by the bench

  always #5 clk = ~clk;

  dma_chan_regs #(.ADDR_W(8)) i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .periph_irq(periph_irq), .irq_out(irq_out),
    .periph_rst_pulse(periph_rst_pulse), .chan_en(chan_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench view of a control write: substitution rules, then protected bits kept
  function automatic logic [31:0] model_ctrl(input logic [31:0] prev, input logic [31:0] v);
    logic [31:0] s;
    s = v;
    if (v == 32'd0) s = 32'h40;
    else if (v[7] == 1'b0 && v[6] == 1'b1) s = v & 32'hFFFF_FFBF;
    return {4'hA, prev[27:25], s[24:3], prev[2:0]};
  endfunction

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
    #1 d = acc_rdata;
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h00, d); check("R1 ctrl", d, 32'hA000_0000);
    bus_read(8'h04, d); check("R1 addr", d, 0);
    bus_read(8'h08, d); check("R1 count", d, 0);
    bus_read(8'h0C, d); check("R1 base", d, 0);
    check("R1 outputs", {29'd0, irq_out, periph_rst_pulse, chan_en}, 0);
  endtask

  task automatic t_plain_words();
    logic [31:0] d;
    bus_write(8'h08, 32'hDEAD_BEEF);
    bus_write(8'h0C, 32'h1234_5678);
    bus_read(8'h08, d); check("R3 count", d, 32'hDEAD_BEEF);
    bus_read(8'h0C, d); check("R3 base", d, 32'h1234_5678);
    bus_read(8'h00, d); check("R3 ctrl untouched", d, ctl);
    bus_read(8'h38, d); check("R2 alias offset 0x38", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_bad_size();
    logic [31:0] d;
    bus_write(8'h08, 32'h0000_0001, 2'd1);
    bus_write(8'h00, 32'h0000_0280, 2'd0);
    bus_read(8'h08, d, 2'd1); check("R2 rejected read", d, 0);
    bus_read(8'h08, d);       check("R2 rejected write", d, 32'hDEAD_BEEF);
    bus_read(8'h00, d);       check("R2 ctrl after rejected", d, ctl);
    check("R2 no pulse/enable", {30'd0, periph_rst_pulse, chan_en}, 0);
  endtask

  task automatic t_addr_load();
    logic [31:0] d;
    bus_write(8'h04, 32'h0000_1000);
    ctl[26] = 1'b1;
    bus_read(8'h04, d); check("R4 addr stored", d, 32'h0000_1000);
    bus_read(8'h00, d); check("R4 loaded bit", d, 32'hA400_0000);
  endtask

  task automatic t_all_ones();
    logic [31:0] d;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 8'h00; acc_wdata = 32'hFFFF_FFFF; acc_size = 2'd2;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R8 pulse high", {31'd0, periph_rst_pulse}, 1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, periph_rst_pulse}, 0);
    ctl = model_ctrl(ctl, 32'hFFFF_FFFF);
    bus_read(8'h00, d); check("R5 protected bits", d, 32'hA5FF_FFF8);
    check("R9 enable rises", {31'd0, chan_en}, 1);
    check("R11 no pending no irq", {31'd0, irq_out}, 0);
  endtask

  task automatic t_zero_and_drain();
    logic [31:0] d;
    bus_write(8'h00, 32'h0);
    ctl = model_ctrl(ctl, 32'h0);
    bus_read(8'h00, d); check("R6 zero becomes drain", d, 32'hA400_0040);
    check("R9 enable falls", {31'd0, chan_en}, 0);
    bus_write(8'h00, 32'h0000_0050);
    ctl = model_ctrl(ctl, 32'h50);
    bus_read(8'h00, d); check("R7 drain cleared", d, 32'hA400_0010);
    check("R7 no pulse", {31'd0, periph_rst_pulse}, 0);
    bus_write(8'h00, 32'h0000_00C0);
    check("R8 pulse with drain", {31'd0, periph_rst_pulse}, 1);
    ctl = model_ctrl(ctl, 32'hC0);
    bus_read(8'h00, d); check("R7 drain kept with reset", d, 32'hA400_00C0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(8'h00, 32'h0000_0200);
    ctl = model_ctrl(ctl, 32'h200);
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    ctl[0] = 1'b1;
    bus_read(8'h00, d); check("R10 pending set", d, ctl);
    check("R11 masked", {31'd0, irq_out}, 0);
    bus_write(8'h00, 32'h0000_0210);
    ctl = model_ctrl(ctl, 32'h210);
    check("R11 unmask asserts at once", {31'd0, irq_out}, 1);
    bus_write(8'h00, 32'h0000_0200);
    check("R11 mask deasserts", {31'd0, irq_out}, 0);
    bus_write(8'h00, 32'h0000_0210);
    check("R11 unmask again", {31'd0, irq_out}, 1);
    @(negedge clk); periph_irq = 1'b0;
    @(negedge clk);
    ctl = model_ctrl(ctl, 32'h210); ctl[0] = 1'b0;
    check("R10 falling deasserts", {31'd0, irq_out}, 0);
    bus_read(8'h00, d); check("R10 pending cleared", d, ctl);
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    check("R11 event while enabled", {31'd0, irq_out}, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ctl = 32'hA000_0000;
        t_reset();
        t_plain_words();
        t_bad_size();
        t_addr_load();
        t_all_ones();
        t_zero_and_drain();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule